// File: doc/BRIEF.md
# Power-Down and Wake Sequencer

This block takes a system into a low-power state on command from the processor and brings it back when an interrupt arrives. The processor writes a request bit. On the next clock edge the block drops the supply-enable line, gates the clock output low, holds the processor in reset and disables the serial interface. The request bit clears itself at that point, so entering power-down again needs a new write.

The block leaves power-down only on an interrupt. There are three wake sources: the alarm, the periodic tick and the line-power monitor. Any one of them starts the wake sequence. The supply comes back first. The clock output is ungated one cycle later. The processor reset is released after a parameterised hold time, and the serial interface comes back one cycle after that.

The gate for the clock output is registered on the falling clock edge, so the gated clock never shows a shortened pulse. The wake inputs are single-bit levels that are already synchronous to the clock.

Top module: `pwrdown_seq`

## Requirements
- R1: While reset (`rstN` low) is asserted, and after it is released with no further stimulus, `supplyEn`, `cpuResetN` and `serialEn` are 1 and `clkOut` follows `clk`.
- R2: A `pdWrite` pulse sampled on rising edge k sets the request bit. Power-down is entered on edge k+1, and from that edge `supplyEn`, `cpuResetN` and `serialEn` read 0.
- R3: For the whole of power-down, `supplyEn` and `cpuResetN` stay 0.
- R4: In power-down `clkOut` stays 0. The clock gate changes only on falling edges of `clk`, so `clkOut` is 0 whenever `clk` is low.
- R5: In power-down, a 1 on any of `wakeAlarm`, `wakePeriodic` or `wakeSense` sampled on rising edge w starts the wake sequence.
- R6: `supplyEn` returns to 1 on edge w, and the clock gate opens on edge w+1. `clkOut` toggles from the clock-high phase after edge w+2.
- R7: `cpuResetN` returns to 1 on edge w+1+RESET_HOLD.
- R8: `serialEn` returns to 1 on edge w+2+RESET_HOLD, and the block is back in normal operation.
- R9: A `pdWrite` sampled while `serialEn` is 0 has no effect: no power-down follows it.
- R10: The request bit clears when power-down is entered. After wake, the block stays in normal operation until a new `pdWrite`.
- R11: Wake inputs have no effect outside power-down, and nothing except `pdWrite` starts power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdWrite | input | 1 | One-cycle write that sets the power-down request |
| wakeAlarm | input | 1 | Alarm interrupt wake source |
| wakePeriodic | input | 1 | Periodic interrupt wake source |
| wakeSense | input | 1 | Line-power monitor interrupt wake source |
| supplyEn | output | 1 | Power-supply enable, high in normal operation |
| clkOut | output | 1 | Gated clock output, held low in power-down |
| cpuResetN | output | 1 | Processor reset, active low |
| serialEn | output | 1 | Serial interface enable |

## Verification
On every cycle, the assertions check the ordering of the outputs: the serial enable never leads the released reset, the reset never leads the open clock gate, and the gate never leads the supply. They also check that the request bit stays clear while the serial interface is off, that the hold counter keeps the sequencer waiting, and that normal operation persists without a request.

Only the bench's scenarios can show the exact cycle of each transition. The bench wakes the block from each of the three sources and checks the clock output in both clock phases. It also shows that writes made during power-down or during wake are ignored, and that a wake pulse in normal operation changes nothing.

// File: rtl/pwrdown_pkg.sv
package pwrdown_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_DOWN   = 3'd1,
    ST_CLK_ON = 3'd2,
    ST_HOLD   = 3'd3,
    ST_SER_ON = 3'd4
  } seqState_t;

  // strobes from the control FSM to the output datapath
  typedef struct packed {
    logic enterDown;
    logic supplyOn;
    logic clockOn;
    logic cntLoad;
    logic resetRelease;
    logic serialOn;
  } seqStrobes_t;

endpackage

// File: rtl/pwrdown_ctrl.sv
module pwrdown_ctrl
  import pwrdown_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqBit,
  input  logic        wakeAlarm,
  input  logic        wakePeriodic,
  input  logic        wakeSense,
  input  logic        cntDone,
  output seqStrobes_t strobes
);

  seqState_t state, stateNext;
  logic wakeAny;

  assign wakeAny = wakeAlarm | wakePeriodic | wakeSense;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_RUN: begin
        if (reqBit) begin
          strobes.enterDown = 1'b1;
          stateNext = ST_DOWN;
        end
      end
      ST_DOWN: begin
        if (wakeAny) begin
          strobes.supplyOn = 1'b1;
          stateNext = ST_CLK_ON;
        end
      end
      ST_CLK_ON: begin
        strobes.clockOn = 1'b1;
        strobes.cntLoad = 1'b1;
        stateNext = ST_HOLD;
      end
      ST_HOLD: begin
        if (cntDone) begin
          strobes.resetRelease = 1'b1;
          stateNext = ST_SER_ON;
        end
      end
      ST_SER_ON: begin
        strobes.serialOn = 1'b1;
        stateNext = ST_RUN;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  // R11: without a pending request the block stays in normal operation
  assert_stay_run_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !reqBit) |=> (state == ST_RUN));

  // R7: the reset hold is not cut short while the counter runs
  assert_hold_wait_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !cntDone) |=> (state == ST_HOLD));

  // R3: power-down is left only when an interrupt is present
  assert_down_needs_wake_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DOWN && !wakeAny) |=> (state == ST_DOWN));

endmodule

// File: rtl/pwrdown_path.sv
module pwrdown_path
  import pwrdown_pkg::*;
#(
  parameter int RESET_HOLD = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pdWrite,
  input  seqStrobes_t strobes,
  output logic        reqBit,
  output logic        cntDone,
  output logic        supplyEn,
  output logic        gateEn,
  output logic        cpuResetN,
  output logic        serialEn
);

  localparam int CNT_W = (RESET_HOLD < 2) ? 1 : $clog2(RESET_HOLD);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(RESET_HOLD - 1);

  logic [CNT_W-1:0] holdCnt;
  logic             gateReq;

  // request bit: writes accepted only while the serial interface is up
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      reqBit <= 1'b0;
    else if (strobes.enterDown)     reqBit <= 1'b0;
    else if (pdWrite && serialEn)   reqBit <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      supplyEn  <= 1'b1;
      gateReq   <= 1'b1;
      cpuResetN <= 1'b1;
      serialEn  <= 1'b1;
    end else begin
      if (strobes.enterDown) begin
        supplyEn  <= 1'b0;
        gateReq   <= 1'b0;
        cpuResetN <= 1'b0;
        serialEn  <= 1'b0;
      end
      if (strobes.supplyOn)     supplyEn  <= 1'b1;
      if (strobes.clockOn)      gateReq   <= 1'b1;
      if (strobes.resetRelease) cpuResetN <= 1'b1;
      if (strobes.serialOn)     serialEn  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdCnt <= '0;
    else if (strobes.cntLoad) holdCnt <= CNT_INIT;
    else if (holdCnt != '0)   holdCnt <= holdCnt - 1'b1;
  end

  assign cntDone = (holdCnt == '0);

  // gate retimed on the falling edge so the gated clock has no runt pulse
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) gateEn <= 1'b1;
    else       gateEn <= gateReq;
  end

  // R8: serial interface only comes back after reset release
  assert_serial_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    serialEn |-> (cpuResetN && supplyEn));

  // R7: reset is never released before the clock gate is opened
  assert_reset_after_clock_R7: assert property (@(posedge clk) disable iff (!rstN)
    cpuResetN |-> gateReq);

  // R6: the clock gate never opens ahead of the supply
  assert_clock_after_supply_R6: assert property (@(posedge clk) disable iff (!rstN)
    gateReq |-> supplyEn);

  // R9 / R10: no request can be pending while the serial interface is off
  assert_write_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    !serialEn |=> !reqBit);

endmodule

// File: rtl/pwrdown_seq.sv
module pwrdown_seq
  import pwrdown_pkg::*;
#(
  parameter int RESET_HOLD = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic pdWrite,
  input  logic wakeAlarm,
  input  logic wakePeriodic,
  input  logic wakeSense,
  output logic supplyEn,
  output logic clkOut,
  output logic cpuResetN,
  output logic serialEn
);

  seqStrobes_t strobes;
  logic reqBit;
  logic cntDone;
  logic gateEn;

  pwrdown_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqBit       (reqBit),
    .wakeAlarm    (wakeAlarm),
    .wakePeriodic (wakePeriodic),
    .wakeSense    (wakeSense),
    .cntDone      (cntDone),
    .strobes      (strobes)
  );

  pwrdown_path #(.RESET_HOLD(RESET_HOLD)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .pdWrite   (pdWrite),
    .strobes   (strobes),
    .reqBit    (reqBit),
    .cntDone   (cntDone),
    .supplyEn  (supplyEn),
    .gateEn    (gateEn),
    .cpuResetN (cpuResetN),
    .serialEn  (serialEn)
  );

  assign clkOut = clk & gateEn;

endmodule

// File: tb/pwrdown_seq_tb.sv
`timescale 1ns/1ps
module pwrdown_seq_tb;

  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pdWrite = 1'b0;
  logic wakeAlarm = 1'b0;
  logic wakePeriodic = 1'b0;
  logic wakeSense = 1'b0;
  logic supplyEn, clkOut, cpuResetN, serialEn;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  pwrdown_seq #(.RESET_HOLD(HOLD)) u_dut (
    .clk(clk), .rstN(rstN), .pdWrite(pdWrite),
    .wakeAlarm(wakeAlarm), .wakePeriodic(wakePeriodic), .wakeSense(wakeSense),
    .supplyEn(supplyEn), .clkOut(clkOut), .cpuResetN(cpuResetN), .serialEn(serialEn)
  );

  // behavioural reference: running / down / wake age
  bit mRun = 1, mReq = 0, mWaking = 0;
  int mAge = 0;
  bit mSupply = 1, mGate = 1, mReset = 1, mSerial = 1, mGatePrev = 1;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit wake, wr;
    wake = wakeAlarm | wakePeriodic | wakeSense;
    wr = pdWrite;
    if (rstN) begin
      mGatePrev = mGate;
      if (mRun) begin
        if (mReq) begin mRun = 0; mWaking = 0; mReq = 0; end
        else if (wr && mSerial) mReq = 1;
      end else if (!mWaking) begin
        if (wake) begin mWaking = 1; mAge = 0; end
      end else begin
        mAge++;
        if (mAge >= HOLD + 2) begin mRun = 1; mWaking = 0; end
      end
      if (mRun) begin
        mSupply = 1; mGate = 1; mReset = 1; mSerial = 1;
      end else if (!mWaking) begin
        mSupply = 0; mGate = 0; mReset = 0; mSerial = 0;
      end else begin
        mSupply = 1; mGate = (mAge >= 1); mReset = (mAge >= HOLD + 1); mSerial = 0;
      end
      #2;
      check("R3/R6 supplyEn", supplyEn, mSupply);
      check("R4/R6 clkOut high phase", clkOut, mGatePrev);
      check("R3/R7 cpuResetN", cpuResetN, mReset);
      check("R2/R8 serialEn", serialEn, mSerial);
    end
  end

  // R4: no pulse on clkOut while clk is low
  always @(negedge clk) begin
    #2;
    if (rstN) check("R4 clkOut low phase", clkOut, 1'b0);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  initial begin : watchdog
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    #12;
    check("R1 supplyEn in reset", supplyEn, 1'b1);
    check("R1 cpuResetN in reset", cpuResetN, 1'b1);
    check("R1 serialEn in reset", serialEn, 1'b1);
    @(negedge clk); rstN = 1'b1;
    cyc(3);

    // R11: wake in normal operation does nothing
    pulse(wakeAlarm);
    pulse(wakeSense);
    cyc(3);
    check("R11 still running", serialEn, 1'b1);

    // R2, R5: alarm wake
    pulse(pdWrite);
    cyc(4);
    check("R2 in power-down", supplyEn, 1'b0);
    // R9: write during power-down ignored
    pulse(pdWrite);
    cyc(5);
    pulse(wakeAlarm);
    cyc(HOLD + 6);
    check("R9 no re-entry after write in down", serialEn, 1'b1);
    // R10: stays running without a new write
    cyc(10);
    check("R10 no re-entry", supplyEn, 1'b1);

    // R5: periodic wake, with write during wake ignored
    pulse(pdWrite);
    cyc(6);
    pulse(wakePeriodic);
    pulse(pdWrite);
    cyc(HOLD + 8);
    check("R9 write during wake ignored", serialEn, 1'b1);

    // R5: sense wake, held for several cycles
    pulse(pdWrite);
    cyc(3);
    @(negedge clk); wakeSense = 1'b1;
    cyc(5);
    wakeSense = 1'b0;
    cyc(HOLD + 6);
    check("R8 back to normal", serialEn, 1'b1);

    // back-to-back: new write right after return
    pulse(pdWrite);
    cyc(4);
    pulse(wakeAlarm);
    cyc(HOLD + 6);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

endmodule